// File: doc/BRIEF.md
# Bank-Switched Memory Map Controller

This block steers every CPU memory access to exactly one of three responders: the on-board RAM, the on-board boot EPROM, or memory on the external system bus. The choice depends on the access address and on a small write-only control register reached through an I/O write. The register holds a separate enable for each quarter of the address space, an enable for the boot EPROM, and a clear for the power-on jump condition. The RAM and ROM arrays themselves sit outside the block. It only produces the three chip selects and the low ROM address bits.

After reset the EPROM is enabled and the power-on jump condition is active. While that condition holds, every memory request is served by the EPROM whatever its address, so the CPU fetches its first instructions from ROM. Software then writes the control port with the jump-clear bit high, which makes RAM reachable. The same write can switch off the EPROM so the RAM under the top window becomes visible. It can also give any RAM quarter to external bus memory, for example to hold per-user banks.

Top module: `memmap_ctrl`

## Requirements
- R1: After reset all RAM quarter enables are 0, the EPROM is enabled and the power-on jump condition is active.
- R2: The control register is written only by an I/O write whose I/O address equals CTRL_PORT (default 16h). Writes to any other I/O address leave every output unchanged.
- R3: With the jump condition cleared, an access in quarter i (address bits 15:14 = i) whose enable bit i (bit 0 to 3 of the control value) is 1 asserts ram_sel, unless the EPROM claims the address.
- R4: With the jump condition cleared, an access in a quarter whose enable bit is 0 asserts ext_sel, unless the EPROM claims the address.
- R5: Control bit 5 = 0 enables the EPROM. It then claims F000h to FFFFh with priority over RAM and external memory. Bit 5 = 1 disables it, and it then claims no address.
- R6: While the jump condition is active, every memory request asserts rom_sel. The condition is cleared only by a control write with bit 6 = 1. A later write with bit 6 = 0 does not restore it; only reset does.
- R7: Control bits 4 and 7 have no effect on any output.
- R8: During a memory request exactly one of ram_sel, rom_sel and ext_sel is 1. With no request all three are 0.
- R9: rom_addr equals the low ROM_DEV_LOG2 bits of the address. With a 2 KB device (ROM_DEV_LOG2 = 11) in the 4 KB window, the image appears twice: F000h+x and F800h+x give the same rom_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | input | ADDR_W (16) | CPU memory address |
| mem_req | input | 1 | Memory access in progress |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | IO_AW (8) | I/O port address |
| io_wdata | input | DATA_W (8) | I/O write data |
| ram_sel | output | 1 | On-board RAM responds |
| rom_sel | output | 1 | Boot EPROM responds |
| ext_sel | output | 1 | External bus memory responds |
| rom_addr | output | ROM_DEV_LOG2 (12) | Address bits passed to the EPROM |

## Verification
The bench builds the block with a 2 KB EPROM (ROM_DEV_LOG2 = 11) inside the default 4 KB window. This setting brings the mirrored image of R9 within reach while keeping the default four-quarter, 16-bit map. With only 32 meaningful register settings once the jump condition is cleared, the bench walks all of them. It toggles the ignored bits along the way and sweeps the whole address space in 128-byte steps for each setting. The jump phase, wrong-port writes and a late write with bit 6 low are checked on the same sweep.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
   // bit positions inside the control value (bank enables occupy bits 0..NUM_BANKS-1)
   localparam int CTRL_ROM_OFF_BIT   = 5;
   localparam int CTRL_JUMP_CLR_BIT  = 6;

   typedef struct packed {
      logic ram;
      logic rom;
      logic ext;
   } mem_sel_t;
endpackage

// File: rtl/memmap_ctrl_reg.sv
module memmap_ctrl_reg #(
   parameter int NUM_BANKS = 4,
   parameter int IO_AW     = 8,
   parameter int DATA_W    = 8,
   parameter logic [IO_AW-1:0] CTRL_PORT = 8'h16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_wr,
   input  logic [IO_AW-1:0]     io_addr,
   input  logic [DATA_W-1:0]    io_wdata,
   output logic [NUM_BANKS-1:0] bank_en_o,
   output logic                 rom_off_o,
   output logic                 jump_o
);
   import memmap_pkg::*;

   generate
      if (NUM_BANKS > CTRL_ROM_OFF_BIT) begin : g_bad_banks
         $error("NUM_BANKS overlaps the EPROM control bit");
      end
      if (DATA_W <= CTRL_JUMP_CLR_BIT) begin : g_bad_width
         $error("DATA_W too narrow for the control bits");
      end
   endgenerate

   logic hit_w;
   assign hit_w = io_wr && (io_addr == CTRL_PORT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_en_o <= '0;
         rom_off_o <= 1'b0;
         jump_o    <= 1'b1;
      end else if (hit_w) begin
         bank_en_o <= io_wdata[NUM_BANKS-1:0];
         rom_off_o <= io_wdata[CTRL_ROM_OFF_BIT];
         if (io_wdata[CTRL_JUMP_CLR_BIT]) jump_o <= 1'b0;
      end
   end

   // once cleared, the jump condition never returns without reset
   assert_jump_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !jump_o |=> !jump_o);

   // register keeps its value when the port is not written
   assert_hold_wrong_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == CTRL_PORT) |=> $stable(bank_en_o) && $stable(rom_off_o));
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode #(
   parameter int ADDR_W       = 16,
   parameter int NUM_BANKS    = 4,
   parameter int ROM_WIN_LOG2 = 12,
   parameter int ROM_DEV_LOG2 = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       mem_addr,
   input  logic                    mem_req,
   input  logic [NUM_BANKS-1:0]    bank_en,
   input  logic                    rom_off,
   input  logic                    jump,
   output memmap_pkg::mem_sel_t    sel,
   output logic [ROM_DEV_LOG2-1:0] rom_addr
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);

   generate
      if (NUM_BANKS < 2 || (1 << BANK_BITS) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (ROM_DEV_LOG2 > ROM_WIN_LOG2 || ROM_WIN_LOG2 >= ADDR_W) begin : g_bad_rom
         $error("ROM device must fit the window and the window the address space");
      end
   endgenerate

   logic [BANK_BITS-1:0] bank_idx;
   logic [NUM_BANKS-1:0] bank_hit;
   logic                 rom_win;
   logic                 rom_hit;
   logic                 ram_hit;

   assign bank_idx = mem_addr[ADDR_W-1 -: BANK_BITS];
   assign rom_win  = &mem_addr[ADDR_W-1:ROM_WIN_LOG2];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_hit[b] = (bank_idx == BANK_BITS'(b)) && bank_en[b];
      end
      if (ROM_DEV_LOG2 < ROM_WIN_LOG2) begin : g_rom_mirror
         // incomplete decode: upper window bits are dropped, image repeats
         assign rom_addr = mem_addr[ROM_DEV_LOG2-1:0];
      end else begin : g_rom_full
         assign rom_addr = mem_addr[ROM_WIN_LOG2-1:0];
      end
   endgenerate

   assign ram_hit = |bank_hit;
   assign rom_hit = jump || (!rom_off && rom_win);

   always_comb begin
      sel = '0;
      if (mem_req) begin
         if (rom_hit)      sel.rom = 1'b1;
         else if (ram_hit) sel.ram = 1'b1;
         else              sel.ext = 1'b1;
      end
   end

   assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> $countones({sel.ram, sel.rom, sel.ext}) == 1);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> sel == '0);
   assert_jump_rom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && jump) |-> sel.rom);
   assert_rom_gone_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !jump && rom_off) |-> !sel.rom);
endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl #(
   parameter int ADDR_W       = 16,
   parameter int NUM_BANKS    = 4,
   parameter int IO_AW        = 8,
   parameter int DATA_W       = 8,
   parameter int ROM_WIN_LOG2 = 12,
   parameter int ROM_DEV_LOG2 = 12,
   parameter logic [IO_AW-1:0] CTRL_PORT = 8'h16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       mem_addr,
   input  logic                    mem_req,
   input  logic                    io_wr,
   input  logic [IO_AW-1:0]        io_addr,
   input  logic [DATA_W-1:0]       io_wdata,
   output logic                    ram_sel,
   output logic                    rom_sel,
   output logic                    ext_sel,
   output logic [ROM_DEV_LOG2-1:0] rom_addr
);
   logic [NUM_BANKS-1:0] bank_en;
   logic                 rom_off;
   logic                 jump;
   memmap_pkg::mem_sel_t sel;

   memmap_ctrl_reg #(
      .NUM_BANKS(NUM_BANKS), .IO_AW(IO_AW), .DATA_W(DATA_W), .CTRL_PORT(CTRL_PORT)
   ) reg_i (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .bank_en_o(bank_en), .rom_off_o(rom_off), .jump_o(jump)
   );

   memmap_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
      .ROM_WIN_LOG2(ROM_WIN_LOG2), .ROM_DEV_LOG2(ROM_DEV_LOG2)
   ) dec_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_req(mem_req),
      .bank_en(bank_en), .rom_off(rom_off), .jump(jump),
      .sel(sel), .rom_addr(rom_addr)
   );

   assign ram_sel = sel.ram;
   assign rom_sel = sel.rom;
   assign ext_sel = sel.ext;

   // reset state: jump condition forces every request to the EPROM (R1)
   assert_reset_rom_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && mem_req) |-> rom_sel);
endmodule

// File: tb/memmap_ctrl_tb_top.sv
`timescale 1ns/1ps
module memmap_ctrl_tb_top;
   localparam int DEV = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr = '0;
   logic        mem_req = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        ram_sel, rom_sel, ext_sel;
   logic [DEV-1:0] rom_addr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model of the register
   logic [3:0] m_banks;
   logic       m_off;
   logic       m_jump;

   always #5 clk = ~clk;

   memmap_ctrl #(.ROM_DEV_LOG2(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_req(mem_req),
      .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .ram_sel(ram_sel), .rom_sel(rom_sel), .ext_sel(ext_sel), .rom_addr(rom_addr)
   );

   function automatic logic [2:0] expect_sel(input logic [15:0] a, input logic req);
      if (!req) return 3'b000;
      if (m_jump) return 3'b010;
      if (!m_off && a[15:12] == 4'hF) return 3'b010;
      if (m_banks[a[15:14]]) return 3'b100;
      return 3'b001;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic probe(input string tag, input logic [15:0] a, input logic req);
      logic [2:0] e;
      mem_addr = a;
      mem_req  = req;
      #1;
      e = expect_sel(a, req);
      check(tag, {29'd0, ram_sel, rom_sel, ext_sel}, {29'd0, e});
      if (e == 3'b010)
         check("R9 rom_addr", {21'd0, rom_addr}, {21'd0, a[DEV-1:0]});
   endtask

   task automatic sweep(input string tag);
      for (int a = 0; a < 65536; a += 128) probe(tag, 16'(a), 1'b1);
      mem_req = 1'b0;
   endtask

   task automatic io_write(input logic [7:0] port, input logic [7:0] v);
      @(negedge clk);
      io_wr = 1'b1; io_addr = port; io_wdata = v;
      @(negedge clk);
      io_wr = 1'b0;
      if (port == 8'h16) begin
         m_banks = v[3:0];
         m_off   = v[5];
         if (v[6]) m_jump = 1'b0;
      end
   endtask

   initial begin
      m_banks = '0; m_off = 1'b0; m_jump = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R6: reset state serves everything from the EPROM
      sweep("R1 reset jump");
      probe("R8 no request", 16'h1234, 1'b0);
      probe("R8 no request top", 16'hF800, 1'b0);
      // R2: wrong port ignored
      io_write(8'h15, 8'h4F);
      io_write(8'h17, 8'h6F);
      sweep("R2 wrong port during jump");
      // R6: bit 6 low does not clear jump
      io_write(8'h16, 8'h0F);
      sweep("R6 jump kept with bit6 low");
      // R3/R4/R5/R7: all settings with jump cleared, junk in bits 4 and 7
      for (int v = 0; v < 32; v++) begin
         logic [7:0] w;
         w = {v[0], 1'b1, v[4], v[1] ^ v[2], v[3:0]};
         io_write(8'h16, w);
         sweep("R3 R4 R5 R7 bank/rom sweep");
      end
      // R9: explicit mirror pair with rom on
      io_write(8'h16, 8'h4F);
      probe("R9 low copy", 16'hF123, 1'b1);
      check("R9 mirror", {21'd0, rom_addr}, 32'h123);
      probe("R9 high copy", 16'hF923, 1'b1);
      check("R9 mirror", {21'd0, rom_addr}, 32'h123);
      // R6: later write with bit6 low does not restore jump
      io_write(8'h16, 8'h00);
      sweep("R6 no jump return");
      // R2: wrong port after release
      io_write(8'h26, 8'h4F);
      sweep("R2 wrong port after release");
      // R1: reset again returns the jump condition
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_banks = '0; m_off = 1'b0; m_jump = 1'b1;
      sweep("R1 re-reset");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule